// File: doc/BRIEF.md
# Parallel Vector Inverse FFT

This block computes an N-point inverse discrete Fourier transform on a whole complex vector every clock. It serves as the channel-combining stage of a polyphase synthesis filter bank: each clock, the N subfilter outputs arrive together as one input vector, and the N time-domain samples leave together as one output vector. The transform runs as log2(N) registered radix-2 decimation-in-frequency stages. Each stage multiplies by twiddle constants that are fixed when the design is built. The output elements are rewired into natural order, so this costs no extra registers.

The parameter `SCALE` selects one of two number formats. With `SCALE=1`, every stage halves its result with round-half-up, so the output keeps the input word length and the overall gain is 1/N. With `SCALE=0`, every stage widens the word by one bit, and the output is N times the scaled result. The parameter `MULT3` chooses how each complex rotation is built: four real multipliers with two adders, or three real multipliers with five adders. Input and output vectors are packed flat, with element k at bits `[k*W +: W]`. The real and imaginary parts travel on separate ports.

Top module: `ifft_vec`

## Requirements
- R1: `NPTS` is a power of two from 4 to 64. A new input vector is accepted on every clock in which `in_vld` is 1, and back-to-back vectors each produce their own output vector.
- R2: With `SCALE=1`, output element n equals (1/N)·Σk X[k]·e^(+j2πkn/N), in natural order, to within 2 LSB in each part.
- R3: With `SCALE=1`, the output width equals the input width `DW`. Every stage halves with round-half-up, so a full-scale DC vector (all bins +32767 or all bins −32768 with DW=16) gives element 0 equal to that value and zero elsewhere, with no wrap.
- R4: With `SCALE=0`, the output width is DW+log2(N) and element n equals Σk X[k]·e^(+j2πkn/N) to within 4 LSB. A full-scale DC vector gives N times the input value in element 0, with no wrap.
- R5: With `MULT3=1`, the three-multiplier rotation gives results inside the same tolerance as R2 and R4.
- R6: `out_vld` rises exactly log2(N) clocks after the clock edge that captured an input vector with `in_vld` at 1.
- R7: A clock with `in_vld` at 0 ignores the input data. In a cycle with `out_vld` at 0, the output data keeps its previous value.
- R8: While `rst_n` is 0 at a clock edge, all pipeline registers clear: after reset, `out_vld` is 0 and the output data is zero, even if `in_vld` was 1 during reset or vectors were in flight.
- R9: An all-zero input vector gives an output vector that is exactly zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers use its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input vector valid |
| in_re | input | NPTS*DW | Real parts of the input vector, element k at [k*DW +: DW] |
| in_im | input | NPTS*DW | Imaginary parts of the input vector |
| out_vld | output | 1 | Output vector valid |
| out_re | output | NPTS*OW | Real parts of the output in natural order; OW = DW if SCALE else DW+log2(NPTS) |
| out_im | output | NPTS*OW | Imaginary parts of the output vector |

## Verification
Two functions can act in the same clock: a synchronous reset, and the capture of a valid input vector while earlier vectors are still moving through the stages. The bench provokes this in two ways. It holds `in_vld` high for several cycles during the power-up reset. Later, it asserts `rst_n` low in the same clock as a new valid vector, while two earlier vectors are still in the pipeline. In both cases it judges the result at the ports: after release, `out_vld` must stay 0 for longer than the pipeline latency and the output data must read zero, so no flushed or concurrently presented vector ever emerges.

// File: rtl/ifft_pkg.sv
// Package ifft_pkg
// Purpose: elaboration-time helpers shared by the vector IFFT modules:
//          rotation constants and index bit reversal.
// Assumes: called only with constant arguments; npts is a power of two.
package ifft_pkg;

    localparam real PI_C = 3.14159265358979323846;

    // Sine by Taylor series on an argument already folded into [-pi, pi].
    function automatic real ser_sin(real x);
        real term;
        real acc;
        term = x;
        acc  = x;
        for (int k = 1; k < 14; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Cosine by Taylor series on an argument already folded into [-pi, pi].
    function automatic real ser_cos(real x);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int k = 1; k < 14; k++) begin
            term = -term * x * x / real'((2 * k - 1) * (2 * k));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Rounded fixed-point part of exp(+j*2*pi*idx/npts), with 1.0 = 2^(tw-2).
    function automatic int rot_const(int npts, int idx, int tw, bit want_im);
        real ang;
        real val;
        ang = 2.0 * PI_C * real'(idx % npts) / real'(npts);
        if (ang > PI_C) ang = ang - 2.0 * PI_C;
        val = (want_im ? ser_sin(ang) : ser_cos(ang)) * real'(1 << (tw - 2));
        return int'(val);
    endfunction

    // Reverse the lowest 'bits' bits of v.
    function automatic int bit_rev(int v, int bits);
        int r;
        r = 0;
        for (int b = 0; b < bits; b++) begin
            if (((v >> b) & 1) != 0) r = r | (1 << (bits - 1 - b));
        end
        return r;
    endfunction

endpackage

// File: rtl/ifft_cmul.sv
// Module ifft_cmul
// Purpose: multiplies a complex sample by a constant rotation (WR + jWI).
//          MULT3 selects three multipliers with five adders instead of
//          four multipliers with two adders.
// Assumes: PW is wide enough for the full product (AW + TW + 1 bits);
//          purely combinational, so the caller registers the result.
module ifft_cmul #(
    parameter int AW    = 17,
    parameter int TW    = 16,
    parameter int PW    = AW + TW + 1,
    parameter bit MULT3 = 1'b0,
    parameter int WR    = 0,
    parameter int WI    = 0
) (
    input  logic signed [AW-1:0] a_re,
    input  logic signed [AW-1:0] a_im,
    output logic signed [PW-1:0] p_re,
    output logic signed [PW-1:0] p_im
);

    localparam logic signed [PW-1:0] CR = PW'(WR);
    localparam logic signed [PW-1:0] CI = PW'(WI);

    logic signed [PW-1:0] xr;
    logic signed [PW-1:0] xi;

    // Sign-extend the operands to the product width.
    assign xr = PW'(a_re);
    assign xi = PW'(a_im);

    if (MULT3) begin : g_m3
        localparam logic signed [PW-1:0] C_DIF = CI - CR;
        localparam logic signed [PW-1:0] C_SUM = CR + CI;
        logic signed [PW-1:0] k1;
        logic signed [PW-1:0] k2;
        logic signed [PW-1:0] k3;
        // Three shared products combined into both parts.
        assign k1   = CR * (xr + xi);
        assign k2   = xr * C_DIF;
        assign k3   = xi * C_SUM;
        assign p_re = k1 - k3;
        assign p_im = k1 + k2;
    end else begin : g_m4
        // Direct four-product form.
        assign p_re = xr * CR - xi * CI;
        assign p_im = xr * CI + xi * CR;
    end

endmodule

// File: rtl/ifft_bfly.sv
// Module ifft_bfly
// Purpose: one radix-2 decimation-in-frequency butterfly. The sum output is
//          a+b; the difference output is (a-b) times a constant rotation.
//          With SCALE, both outputs are halved with round-half-up.
// Assumes: OW == IW when SCALE, OW == IW+1 otherwise; combinational only.
//          UNITY removes the multiplier when the rotation is exactly 1.
module ifft_bfly #(
    parameter int IW    = 16,
    parameter int OW    = 16,
    parameter int TW    = 16,
    parameter bit SCALE = 1'b1,
    parameter bit MULT3 = 1'b0,
    parameter bit UNITY = 1'b0,
    parameter int WR    = 0,
    parameter int WI    = 0
) (
    input  logic signed [IW-1:0] a_re,
    input  logic signed [IW-1:0] a_im,
    input  logic signed [IW-1:0] b_re,
    input  logic signed [IW-1:0] b_im,
    output logic signed [OW-1:0] s_re,
    output logic signed [OW-1:0] s_im,
    output logic signed [OW-1:0] d_re,
    output logic signed [OW-1:0] d_im
);

    localparam int SW = IW + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1);

    logic signed [SW-1:0] sr;
    logic signed [SW-1:0] si;
    logic signed [SW-1:0] dr;
    logic signed [SW-1:0] di;

    // Full-precision sum and difference of the two inputs.
    assign sr = SW'(a_re) + SW'(b_re);
    assign si = SW'(a_im) + SW'(b_im);
    assign dr = SW'(a_re) - SW'(b_re);
    assign di = SW'(a_im) - SW'(b_im);

    if (SCALE) begin : g_sum_half
        // Halve the sum with round-half-up; the result always fits IW bits.
        assign s_re = OW'((sr + HALF) >>> 1);
        assign s_im = OW'((si + HALF) >>> 1);
    end else begin : g_sum_grow
        assign s_re = OW'(sr);
        assign s_im = OW'(si);
    end

    if (UNITY) begin : g_dif_unit
        if (SCALE) begin : g_half
            assign d_re = OW'((dr + HALF) >>> 1);
            assign d_im = OW'((di + HALF) >>> 1);
        end else begin : g_grow
            assign d_re = OW'(dr);
            assign d_im = OW'(di);
        end
    end else begin : g_dif_rot
        localparam int PW = SW + TW + 1;
        localparam int SH = TW - 2 + (SCALE ? 1 : 0);
        localparam logic signed [PW-1:0] RND  = PW'(64'sd1 <<< (SH - 1));
        localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OW - 1)) - 64'sd1);
        localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

        logic signed [PW-1:0] p_re;
        logic signed [PW-1:0] p_im;
        logic signed [PW-1:0] r_re;
        logic signed [PW-1:0] r_im;

        ifft_cmul #(
            .AW(SW), .TW(TW), .PW(PW), .MULT3(MULT3), .WR(WR), .WI(WI)
        ) u_cmul (
            .a_re(dr), .a_im(di), .p_re(p_re), .p_im(p_im)
        );

        // Drop the fraction bits with round-half-up, plus the stage halving.
        assign r_re = (p_re + RND) >>> SH;
        assign r_im = (p_im + RND) >>> SH;

        // Clip the rotated parts to the stage width instead of wrapping.
        always_comb begin
            if (r_re > MAXV)      d_re = MAXV[OW-1:0];
            else if (r_re < MINV) d_re = MINV[OW-1:0];
            else                  d_re = r_re[OW-1:0];
            if (r_im > MAXV)      d_im = MAXV[OW-1:0];
            else if (r_im < MINV) d_im = MINV[OW-1:0];
            else                  d_im = r_im[OW-1:0];
        end
    end

endmodule

// File: rtl/ifft_stage.sv
// Module ifft_stage
// Purpose: one registered decimation-in-frequency stage of the vector IFFT.
//          Stage STG pairs elements that lie NPTS>>(STG+1) apart and applies
//          the rotation exp(+j*2*pi*k*2^STG/NPTS) to the difference branch.
// Assumes: NPTS is a power of two; the vector registers load only on valid;
//          synchronous active-low reset clears the data and the valid flag.
module ifft_stage #(
    parameter int NPTS  = 8,
    parameter int STG   = 0,
    parameter int IW    = 16,
    parameter int OW    = 16,
    parameter int TW    = 16,
    parameter bit SCALE = 1'b1,
    parameter bit MULT3 = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vi,
    input  logic [NPTS*IW-1:0] dre,
    input  logic [NPTS*IW-1:0] dim,
    output logic               vo,
    output logic [NPTS*OW-1:0] qre,
    output logic [NPTS*OW-1:0] qim
);

    localparam int SPAN = NPTS >> (STG + 1);

    logic signed [OW-1:0] nre [NPTS];
    logic signed [OW-1:0] nim [NPTS];

    for (genvar p = 0; p < NPTS / 2; p++) begin : g_bf
        localparam int K  = p % SPAN;
        localparam int EI = (p / SPAN) * 2 * SPAN + K;
        localparam int EJ = EI + SPAN;
        localparam int T  = (K << STG) % NPTS;
        localparam int WR = ifft_pkg::rot_const(NPTS, T, TW, 1'b0);
        localparam int WI = ifft_pkg::rot_const(NPTS, T, TW, 1'b1);

        ifft_bfly #(
            .IW(IW), .OW(OW), .TW(TW), .SCALE(SCALE), .MULT3(MULT3),
            .UNITY(T == 0), .WR(WR), .WI(WI)
        ) u_bfly (
            .a_re(dre[EI*IW +: IW]),
            .a_im(dim[EI*IW +: IW]),
            .b_re(dre[EJ*IW +: IW]),
            .b_im(dim[EJ*IW +: IW]),
            .s_re(nre[EI]),
            .s_im(nim[EI]),
            .d_re(nre[EJ]),
            .d_im(nim[EJ])
        );
    end

    // Stage register: clear on reset, load a new vector only when valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vo  <= 1'b0;
            qre <= '0;
            qim <= '0;
        end else begin
            vo <= vi;
            if (vi) begin
                for (int e = 0; e < NPTS; e++) begin
                    qre[e*OW +: OW] <= nre[e];
                    qim[e*OW +: OW] <= nim[e];
                end
            end
        end
    end

endmodule

// File: rtl/ifft_vec.sv
// Module ifft_vec
// Purpose: fully parallel pipelined N-point inverse FFT, one complex vector
//          per clock. It chains log2(NPTS) stages and rewires the
//          bit-reversed result of the last stage into natural order.
// Assumes: NPTS is a power of two from 4 to 64; latency is log2(NPTS)
//          clocks; SCALE=1 halves at each stage, SCALE=0 grows one bit per
//          stage; rst_n is synchronous and active low.
module ifft_vec #(
    parameter int NPTS  = 8,
    parameter int DW    = 16,
    parameter int TW    = 16,
    parameter bit SCALE = 1'b1,
    parameter bit MULT3 = 1'b0,
    localparam int LG   = $clog2(NPTS),
    localparam int OW   = SCALE ? DW : DW + LG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_vld,
    input  logic [NPTS*DW-1:0] in_re,
    input  logic [NPTS*DW-1:0] in_im,
    output logic               out_vld,
    output logic [NPTS*OW-1:0] out_re,
    output logic [NPTS*OW-1:0] out_im
);

    for (genvar s = 0; s < LG; s++) begin : g_st
        localparam int SIW = SCALE ? DW : DW + s;
        localparam int SOW = SCALE ? DW : DW + s + 1;
        logic               vld;
        logic [NPTS*SOW-1:0] q_re;
        logic [NPTS*SOW-1:0] q_im;

        if (s == 0) begin : g_first
            ifft_stage #(
                .NPTS(NPTS), .STG(s), .IW(SIW), .OW(SOW), .TW(TW),
                .SCALE(SCALE), .MULT3(MULT3)
            ) u_stage (
                .clk(clk), .rst_n(rst_n), .vi(in_vld),
                .dre(in_re), .dim(in_im),
                .vo(vld), .qre(q_re), .qim(q_im)
            );
        end else begin : g_next
            ifft_stage #(
                .NPTS(NPTS), .STG(s), .IW(SIW), .OW(SOW), .TW(TW),
                .SCALE(SCALE), .MULT3(MULT3)
            ) u_stage (
                .clk(clk), .rst_n(rst_n), .vi(g_st[s-1].vld),
                .dre(g_st[s-1].q_re), .dim(g_st[s-1].q_im),
                .vo(vld), .qre(q_re), .qim(q_im)
            );
        end
    end

    assign out_vld = g_st[LG-1].vld;

    // Natural-order output: element n comes from position bitrev(n).
    for (genvar n = 0; n < NPTS; n++) begin : g_ord
        localparam int SRC = ifft_pkg::bit_rev(n, LG);
        assign out_re[n*OW +: OW] = g_st[LG-1].q_re[SRC*OW +: OW];
        assign out_im[n*OW +: OW] = g_st[LG-1].q_im[SRC*OW +: OW];
    end

endmodule

// File: rtl/ifft_vec_chk.sv
// Module ifft_vec_chk
// Purpose: temporal checks on the vector IFFT ports, bound to every instance.
// Assumes: synchronous active-low reset; the latency equals log2(NPTS).
module ifft_vec_chk #(
    parameter int NPTS = 8,
    parameter int DW   = 16,
    parameter int OW   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_vld,
    input logic [NPTS*DW-1:0] in_re,
    input logic [NPTS*DW-1:0] in_im,
    input logic               out_vld,
    input logic [NPTS*OW-1:0] out_re,
    input logic [NPTS*OW-1:0] out_im
);

    localparam int LG = $clog2(NPTS);

    logic [7:0] age;

    // Count clocks since reset release, saturating at the latency.
    always_ff @(posedge clk) begin
        if (!rst_n)                 age <= '0;
        else if (age < 8'(LG))      age <= age + 8'd1;
    end

    // R6: output valid follows input valid after exactly the latency.
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 8'(LG)) |-> (out_vld == $past(in_vld, LG)));

    // R9: an all-zero valid input gives an exactly zero output.
    a_r9_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        ((age == 8'(LG)) && $past(in_vld && (in_re == '0) && (in_im == '0), LG))
        |-> (out_vld && (out_re == '0) && (out_im == '0)));

    // R7: without a valid result, the output data does not move.
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((age != 8'd0) && !out_vld) |-> ($stable(out_re) && $stable(out_im)));

    // R8: on leaving reset, nothing valid and the data reads zero.
    a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_vld && (out_re == '0) && (out_im == '0)));

endmodule

bind ifft_vec ifft_vec_chk #(.NPTS(NPTS), .DW(DW), .OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
    .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
);

// File: tb/ifft_vec_tb_top.sv
// Bench for ifft_vec: a scaled four-multiplier instance and a growing
// three-multiplier instance share one stimulus. Expected values come from
// a real-valued inverse DFT.
module ifft_vec_tb_top;

    localparam int  N   = 8;
    localparam int  DW  = 16;
    localparam int  LG  = 3;
    localparam int  OS  = DW;
    localparam int  OU  = DW + LG;
    localparam int  NE  = 7;
    localparam real TOL_S = 2.0;
    localparam real TOL_U = 4.0;
    localparam real PI  = 3.14159265358979323846;

    // kind 0: up to two tones (bin, re, im); kind 1: every bin = (r0, i0)
    typedef struct packed {
        int kind; int b0; int r0; int i0; int b1; int r1; int i1;
    } vec_t;

    localparam vec_t TBL [NE] = '{
        '{0, 0,   1000,     0, 0,    0,    0},
        '{0, 1,   4000,     0, 0,    0,    0},
        '{0, 3,      0, -3000, 5, 2000, 1500},
        '{0, 2,  -2500,   700, 7, 1200, -900},
        '{1, 0,  32767,     0, 0,    0,    0},
        '{1, 0, -32768,     0, 0,    0,    0},
        '{0, 0,      0,     0, 0,    0,    0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_vld = 1'b0;
    logic [N*DW-1:0]   in_re = '0;
    logic [N*DW-1:0]   in_im = '0;
    logic              vld_s, vld_u;
    logic [N*OS-1:0]   re_s, im_s;
    logic [N*OU-1:0]   re_u, im_u;

    int checks = 0;
    int failures = 0;
    int seq [256];
    int wp = 0;
    int rp = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    logic [N*OS-1:0] last_re_s, last_im_s;

    always #10 clk = ~clk;

    ifft_vec #(.NPTS(N), .DW(DW), .TW(16), .SCALE(1'b1), .MULT3(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .out_vld(vld_s), .out_re(re_s), .out_im(im_s)
    );

    ifft_vec #(.NPTS(N), .DW(DW), .TW(16), .SCALE(1'b0), .MULT3(1'b1)) dut_u (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .out_vld(vld_u), .out_re(re_u), .out_im(im_u)
    );

    function automatic int bin_val(int e, int k, bit im);
        vec_t v;
        v = TBL[e];
        if (v.kind == 1) return im ? v.i0 : v.r0;
        return ((k == v.b0) ? (im ? v.i0 : v.r0) : 0) +
               ((k == v.b1) ? (im ? v.i1 : v.r1) : 0);
    endfunction

    function automatic real ref_val(int e, int n, bit im, bit scaled);
        real acc;
        real a;
        acc = 0.0;
        for (int k = 0; k < N; k++) begin
            a = 2.0 * PI * real'(k * n) / real'(N);
            if (im) acc += real'(bin_val(e, k, 0)) * $sin(a) + real'(bin_val(e, k, 1)) * $cos(a);
            else    acc += real'(bin_val(e, k, 0)) * $cos(a) - real'(bin_val(e, k, 1)) * $sin(a);
        end
        return scaled ? acc / real'(N) : acc;
    endfunction

    task automatic expect_near(string req, string what, int act, real expd, real tol);
        real d;
        d = real'(act) - expd;
        if (d < 0.0) d = -d;
        checks++;
        if (d > tol) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0.2f", req, what, act, expd);
        end
    endtask

    task automatic expect_eq(string req, string what, longint act, longint expd);
        checks++;
        if (act != expd) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expd);
        end
    endtask

    // Compare both instances against the reference for table entry e.
    task automatic check_vec(int e);
        string rs, ru;
        rs = (TBL[e].kind == 1) ? "R3" : "R2";
        ru = (TBL[e].kind == 1) ? "R4" : "R5";
        for (int n = 0; n < N; n++) begin
            expect_near(rs, $sformatf("scaled vec%0d re[%0d]", e, n),
                        int'($signed(re_s[n*OS +: OS])), ref_val(e, n, 0, 1), TOL_S);
            expect_near(rs, $sformatf("scaled vec%0d im[%0d]", e, n),
                        int'($signed(im_s[n*OS +: OS])), ref_val(e, n, 1, 1), TOL_S);
            expect_near(ru, $sformatf("grow vec%0d re[%0d]", e, n),
                        int'($signed(re_u[n*OU +: OU])), ref_val(e, n, 0, 0), TOL_U);
            expect_near(ru, $sformatf("grow vec%0d im[%0d]", e, n),
                        int'($signed(im_u[n*OU +: OU])), ref_val(e, n, 1, 0), TOL_U);
        end
    endtask

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (mon_en && (vld_s || vld_u)) begin
            expect_eq("R6", "valid agreement of both instances", longint'(vld_u), longint'(vld_s));
            if (rp < wp) begin
                check_vec(seq[rp]);
                rp++;
            end else begin
                expect_eq("R1", "unexpected extra output vector", 1, 0);
            end
            last_re_s = re_s;
            last_im_s = im_s;
        end
    end

    task automatic send(int e);
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            in_re[k*DW +: DW] = DW'(bin_val(e, k, 0));
            in_im[k*DW +: DW] = DW'(bin_val(e, k, 1));
        end
        in_vld = 1'b1;
        seq[wp] = e;
        wp++;
    endtask

    task automatic idle(int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    task automatic check_cleared(string tag);
        for (int c = 0; c < LG + 2; c++) begin
            @(negedge clk);
            in_vld = 1'b0;
            expect_eq("R8", {tag, " out_vld after reset"}, longint'(vld_s | vld_u), 0);
            expect_eq("R8", {tag, " data after reset"},
                      longint'((re_s != '0) || (im_s != '0) || (re_u != '0) || (im_u != '0)), 0);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    initial begin
        int lat;
        // R8: valid data presented during reset must not emerge.
        in_re  = {N{16'h1234}};
        in_im  = {N{16'h0F0F}};
        in_vld = 1'b1;
        repeat (4) @(negedge clk);
        rst_n  = 1'b1;
        in_vld = 1'b0;
        check_cleared("power-up");

        mon_en = 1'b1;

        // R6: latency of a single vector.
        send(1);
        lat = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            in_vld = 1'b0;
            lat++;
            if (vld_s) break;
        end
        expect_eq("R6", "cycles from capture to out_vld", lat, LG);
        idle(LG + 2);

        // R1..R5, R9: whole table back-to-back.
        for (int e = 0; e < NE; e++) send(e);
        idle(LG + 3);
        expect_eq("R1", "back-to-back vectors all returned", rp, wp);

        // R9: the final table entry was all zero, so output must be exactly zero.
        expect_eq("R9", "zero in gives exact zero out",
                  longint'((last_re_s != '0) || (last_im_s != '0)), 0);

        // R7: idle clocks with changing garbage input leave the output held.
        send(3);
        idle(LG + 2);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_re  = {N{16'(16'h5A5A + c)}};
            in_im  = {N{16'(16'hA5A5 - c)}};
            expect_eq("R7", "no valid while in_vld low", longint'(vld_s), 0);
            expect_eq("R7", "output held while idle",
                      longint'((re_s == last_re_s) && (im_s == last_im_s)), 1);
        end

        // R1: vectors separated by gaps.
        for (int e = NE - 1; e >= 0; e--) begin
            send(e);
            idle(2);
        end
        idle(LG + 2);
        expect_eq("R1", "gapped vectors all returned", rp, wp);

        // R8: reset in the same clock as a new valid vector, others in flight.
        send(2);
        send(3);
        @(negedge clk);
        in_vld = 1'b1;
        rst_n  = 1'b0;
        @(negedge clk);
        rst_n  = 1'b1;
        in_vld = 1'b0;
        rp = wp;
        check_cleared("mid-flight");

        // After the flush the pipeline works again.
        send(4);
        idle(LG + 2);
        expect_eq("R1", "vector after flush returned", rp, wp);

        summary();
    end

endmodule